// File: doc/BRIEF.md
# Weighted Two-Requester Bus Arbiter

This block decides which of two DMA requesters, a receive engine and a transmit engine, owns a single shared bus master port. Ownership is handed out in turns. At the start of a turn the winner is loaded with a transfer credit of one, two, four or eight transfers, chosen by a 2-bit exponent programmed separately for each side. A turn ends when the credit is spent, counted on a transfer-done pulse, or when the owner withdraws its request. At that boundary the grant moves to the other side if that side is asking.

A 5-bit configuration register, written through a simple write-enable port, holds the two exponents and a flag that turns rotation off. With rotation off, the receive side wins every boundary at which it is requesting. The grant is held in a register, is one-hot, and is qualified by the owner's live request. The current arbiter state is driven out as a 2-bit code.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: After reset the grant is 00, the state code is 0, both exponents are 0 (one transfer per turn) and rotation is enabled.
- R2: A turn started with exponent code n (0,1,2,3) lasts exactly 1<<n transfer-done pulses (1,2,4,8) while the owner keeps requesting.
- R3: A write with cfg_we high loads cfg_wdata into the register at the clock edge. Bits [1:0] are the receive exponent, bits [3:2] the transmit exponent, and bit [4]=1 disables rotation.
- R4: With rotation enabled and both sides requesting, turns alternate. From the idle state the side that did not own the last turn goes first, and the receive side goes first after reset.
- R5: A turn ends in the cycle its owner's request is low, and the next owner takes over at the following edge with no idle cycle between them.
- R6: With rotation disabled, the receive side wins every turn boundary at which it requests, including immediately after its own turn.
- R7: The credit of a turn is taken from the register value held at the edge where the turn starts. A write made during a turn, or at the edge that starts a turn, affects only later turns.
- R8: A sole requester keeps the grant across boundaries, and its credit is reloaded at each boundary.
- R9: grant[0] (receive) and grant[1] (transmit) are never both high, and each is high only while its own request is high.
- R10: A transfer-done pulse while nobody holds a grant consumes no credit.
- R11: The state code is 0 when idle, 1 during a receive turn and 2 during a transmit turn, and the grant is 00 whenever the state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_req | input | 1 | Receive requester wants the bus |
| tx_req | input | 1 | Transmit requester wants the bus |
| xfer_done | input | 1 | One transfer by the current owner completed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| grant | output | 2 | Bit 0 receive grant, bit 1 transmit grant |
| arb_state | output | 2 | 0 idle, 1 receive turn, 2 transmit turn |

## Verification
Two events can fall in the same cycle: a configuration write, and a turn boundary caused by the last credited transfer. The bench drives a write with new exponents in the very cycle that carries the final transfer-done pulse of a turn. The turn that starts at that edge must still run for the length set by the old exponent, and only the turn after it may use the new one. A second collision, a request drop in the same cycle as a transfer-done pulse, is also driven. The bench checks it against a cycle-level model of the turn rules that it compares every cycle.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
    parameter int WEIGHT_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [2*WEIGHT_W:0]   wdata,
    output logic [WEIGHT_W-1:0]   rx_w,
    output logic [WEIGHT_W-1:0]   tx_w,
    output logic                  rr_dis
);
    localparam int CFG_W = 2*WEIGHT_W + 1;

    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rx_w   = cfg_q[WEIGHT_W-1:0];
    assign tx_w   = cfg_q[2*WEIGHT_W-1:WEIGHT_W];
    assign rr_dis = cfg_q[CFG_W-1];
endmodule

// File: rtl/arb_credit.sv
module arb_credit #(
    parameter int WEIGHT_W = 2,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WEIGHT_W-1:0] load_w,
    input  logic                dec,
    output logic [CNT_W-1:0]    cnt,
    output logic                last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                   cnt_d = CNT_W'(1) << load_w;
        else if (dec && cnt_q != 0) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import wrr_arb_pkg::*;
(
    input  logic   rx_req,
    input  logic   tx_req,
    input  logic   rr_dis,
    input  logic   prefer_tx,
    output owner_e pick
);
    always_comb begin
        pick = OWN_IDLE;
        if (rx_req && tx_req) begin
            if (rr_dis)         pick = OWN_RX;
            else if (prefer_tx) pick = OWN_TX;
            else                pick = OWN_RX;
        end else if (rx_req) begin
            pick = OWN_RX;
        end else if (tx_req) begin
            pick = OWN_TX;
        end
    end
endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int WEIGHT_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_req,
    input  logic                tx_req,
    input  logic                xfer_done,
    input  logic                cfg_we,
    input  logic [2*WEIGHT_W:0] cfg_wdata,
    output logic [1:0]          grant,
    output logic [1:0]          arb_state
);
    localparam int MAX_CREDIT = 1 << ((1 << WEIGHT_W) - 1);
    localparam int CNT_W      = $clog2(MAX_CREDIT + 1);

    typedef struct packed {
        owner_e owner;
        logic   last_tx;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [WEIGHT_W-1:0] rx_w, tx_w, load_w;
    logic                rr_dis;
    logic [CNT_W-1:0]    credit;
    logic                credit_last;
    logic                own_req, in_turn, turn_end, boundary;
    logic                prefer_tx, load, dec;
    owner_e              pick;

    arb_cfg_reg #(.WEIGHT_W(WEIGHT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rx_w(rx_w), .tx_w(tx_w), .rr_dis(rr_dis)
    );

    arb_pick u_pick (
        .rx_req(rx_req), .tx_req(tx_req), .rr_dis(rr_dis),
        .prefer_tx(prefer_tx), .pick(pick)
    );

    arb_credit #(.WEIGHT_W(WEIGHT_W), .CNT_W(CNT_W)) u_credit (
        .clk(clk), .rst_n(rst_n), .load(load), .load_w(load_w),
        .dec(dec), .cnt(credit), .last(credit_last)
    );

    always_comb begin
        st_d      = st_q;
        in_turn   = (st_q.owner != OWN_IDLE);
        own_req   = (st_q.owner == OWN_RX) ? rx_req :
                    (st_q.owner == OWN_TX) ? tx_req : 1'b0;
        turn_end  = in_turn && (!own_req || (xfer_done && credit_last));
        boundary  = !in_turn || turn_end;
        prefer_tx = in_turn ? (st_q.owner == OWN_RX) : !st_q.last_tx;
        load      = boundary && (pick != OWN_IDLE);
        load_w    = (pick == OWN_TX) ? tx_w : rx_w;
        dec       = in_turn && own_req && xfer_done && !turn_end;
        if (boundary) st_d.owner = pick;
        if (load)     st_d.last_tx = (pick == OWN_TX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.owner   <= OWN_IDLE;
            st_q.last_tx <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = {(st_q.owner == OWN_TX) && tx_req, (st_q.owner == OWN_RX) && rx_req};
    assign arb_state = st_q.owner;

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idle_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_state == 2'd0) |-> (grant == 2'b00));

    assert_credit_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_turn |-> (credit != '0 && credit <= CNT_W'(MAX_CREDIT)));

    assert_drop_ends_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == OWN_RX && !rx_req) |=> (st_q.owner != OWN_RX));

    assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_dis && st_q.owner == OWN_RX && rx_req && tx_req && xfer_done && credit_last)
        |=> (st_q.owner == OWN_TX));

    assert_rx_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_dis && !in_turn && rx_req) |=> (st_q.owner == OWN_RX));

    assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_turn && !rx_req && !tx_req) |=> (st_q.owner == OWN_IDLE));
endmodule

// File: tb/wrr_bus_arbiter_test.sv
module wrr_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_req = 1'b0, tx_req = 1'b0, xfer_done = 1'b0, cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [1:0] grant, arb_state;

    int vectors = 0, errors = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    int         m_own = 0, m_last = 2, m_cred = 0;
    logic [4:0] m_cfg = '0;

    always #4 clk = ~clk;

    wrr_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
        .xfer_done(xfer_done), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .grant(grant), .arb_state(arb_state)
    );

    function automatic int choose(logic rx, logic tx, int pref);
        if (rx && tx) return m_cfg[4] ? 1 : pref;
        if (rx) return 1;
        if (tx) return 2;
        return 0;
    endfunction

    task automatic tick(input logic rx, input logic tx, input logic done,
                        input string tag, input logic we = 1'b0, input logic [4:0] wd = '0);
        int nxt;
        logic oreq, fin;
        logic [1:0] eg;
        @(negedge clk);
        rx_req = rx; tx_req = tx; xfer_done = done; cfg_we = we; cfg_wdata = wd;
        nxt = m_own;
        if (m_own == 0) begin
            nxt = choose(rx, tx, (m_last == 2) ? 1 : 2);
            if (nxt != 0) begin m_cred = 1 << ((nxt == 1) ? m_cfg[1:0] : m_cfg[3:2]); m_last = nxt; end
        end else begin
            oreq = (m_own == 1) ? rx : tx;
            fin  = !oreq || (done && m_cred == 1);
            if (!fin) begin
                if (done) m_cred--;
            end else begin
                nxt = choose(rx, tx, (m_own == 1) ? 2 : 1);
                if (nxt != 0) begin m_cred = 1 << ((nxt == 1) ? m_cfg[1:0] : m_cfg[3:2]); m_last = nxt; end
            end
        end
        m_own = nxt;
        if (we) m_cfg = wd;
        eg = {(m_own == 2) && tx, (m_own == 1) && rx};
        exp_q.push_back({2'(m_own), eg});
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        logic [3:0] e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if ({arb_state, grant} !== e) begin
                    errors++;
                    $display("FAIL %s: state/grant got %b/%b expected %b/%b",
                             t, arb_state, grant, e[3:2], e[1:0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #2;
        vectors++;
        if (grant !== 2'b00 || arb_state !== 2'd0) begin
            errors++;
            $display("FAIL R1: reset got %b/%b expected 00/00", arb_state, grant);
        end
        @(negedge clk); rst_n = 1'b1;

        // R10: done pulses while idle consume nothing
        for (int i = 0; i < 3; i++) tick(0, 0, 1, "R10");
        // R1/R4: default x1 credit, alternation, rx first
        for (int i = 0; i < 8; i++) tick(1, 1, 1, "R4");
        for (int i = 0; i < 2; i++) tick(0, 0, 0, "R11");
        // R3/R2: rx exponent 1 (bits[1:0]) -> 2 transfers, tx 1
        tick(0, 0, 0, "R3", 1'b1, 5'b00001);
        for (int i = 0; i < 12; i++) tick(1, 1, 1, "R2");
        tick(0, 0, 0, "R11");
        // R2: tx exponent 3 (bits[3:2]) -> 8 transfers
        tick(0, 0, 0, "R3", 1'b1, 5'b01100);
        for (int i = 0; i < 24; i++) tick(1, 1, (i % 3) != 2, "R2");
        // R5: owner drops its request mid-turn, with done in same cycle
        for (int i = 0; i < 3; i++) tick(1, 1, 0, "R5");
        tick(0, 1, 1, "R5");
        tick(1, 0, 1, "R5");
        tick(1, 0, 0, "R9");
        tick(0, 0, 0, "R9");
        // R8: sole requester keeps grant, credit reloads
        tick(0, 0, 0, "R8", 1'b1, 5'b00100);
        for (int i = 0; i < 10; i++) tick(0, 1, 1, "R8");
        tick(0, 0, 0, "R8");
        // R6: rotation disabled, rx always wins
        tick(0, 0, 0, "R6", 1'b1, 5'b10000);
        for (int i = 0; i < 8; i++) tick(1, 1, 1, "R6");
        tick(0, 1, 1, "R6");
        tick(1, 1, 1, "R6");
        tick(0, 0, 0, "R6", 1'b1, 5'b00010);
        // R7: write mid-turn and at the boundary edge
        tick(1, 1, 0, "R7");
        tick(1, 1, 1, "R7", 1'b1, 5'b00000);
        tick(1, 1, 1, "R7");
        tick(1, 1, 1, "R7", 1'b1, 5'b00011);
        for (int i = 0; i < 6; i++) tick(1, 1, 1, "R7");
        for (int i = 0; i < 12; i++) tick(1, 1, 1, "R7");
        tick(0, 0, 0, "R11");
        repeat (3) @(posedge clk);
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule